// File: doc/BRIEF.md
# Packed-Slot Instruction Word Sequencer

This block walks a stream of 16-bit instruction words, each packing one single-bit leading slot and three 5-bit slots. It fetches a word, then takes the slots one after another with no overlap. For each slot that is not a no-op, it presents an opcode to an execution stage and holds it until the stage accepts it. The execution stage handles the arithmetic, the stacks and the data memory. The sequencer has one instruction-memory read port with a single cycle of read latency. It uses the same port both for instruction words and for inline literal operands, which it takes from the words that follow the current instruction word.

Branches and calls build their destination from the bits of the word that lie below their own slot, so the reach of a branch shrinks the later it sits in the word. A branch in the last slot has no such bits and takes its destination from a stack-top input. Literal instructions consume whole words or single bytes from the following words in slot order. The next instruction word is fetched at the first word boundary past everything consumed.

Top module: `packed_slot_seq`

## Requirements
- R1: Word layout: bit 15 is slot 0 (1 means call, 0 means no-op), bits 14:10 are slot 1, bits 9:5 are slot 2, and bits 4:0 are slot 3. The slots are handled in order 0, 1, 2, 3.
- R2: Opcode 0 is a no-op. It is never presented on the output, and the sequencer moves to the next slot.
- R3: While opValid is high and opDone is low, opValid stays high and opCode, opLiteral and opTarget stay stable. The cycle after opDone is seen with opValid, opValid is low.
- R4: A call (opcode 1) or jump (opcode 2) in slot 0, 1 or 2 replaces only the low 15, 10 or 5 bits of the current word's address with the word's low 15, 10 or 5 bits. The upper address bits are kept.
- R5: A call or jump in slot 3 takes its destination from stackTop.
- R6: On a call, opLink gives the address of the word that would have been fetched next without the call: the word past the instruction word and every literal word consumed so far.
- R7: After an accepted call or jump, the remaining slots of the word are discarded and the next fetch address is the destination.
- R8: A word literal (opcode 4) takes the next unconsumed whole word after the instruction word. If the previous byte literal left a half-used word, that word is skipped first. Several literals in one word consume words in slot order.
- R9: A byte literal (opcode 5) takes the high byte of the next literal word, zero-extended. The byte literal after it takes the low byte of that same word.
- R10: After slot 3, the next instruction word is at the first whole word past all consumed literal words. A word with only its high byte used counts as consumed.
- R11: During reset, opValid is low and imemAddr equals the reset address. Execution starts with a fetch from that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| imemAddr | output | ADDR_W | Instruction-memory word address |
| imemData | input | 16 | Read data, valid one cycle after the address |
| stackTop | input | ADDR_W | Top of return stack, destination for slot-3 branches |
| opValid | output | 1 | An opcode is presented |
| opCode | output | 5 | Opcode of the current slot |
| opLiteral | output | 16 | Literal operand for opcodes 4 and 5 |
| opTarget | output | ADDR_W | Destination for call and jump |
| opLink | output | ADDR_W | Return address for call |
| opDone | input | 1 | Execution stage accepts the presented opcode |

## Verification
Directed word programs are compared with a reference model of the slot rules. One program chains plain opcodes with branches in each slot. It separates the 15-, 10- and 5-bit destination widths from the stack-top case and shows whether the upper address bits are kept. A second program mixes word and byte literals in every slot, including a word literal after a lone byte literal and a word with a single byte literal. This exposes errors in the order of consumption, the byte choice and the realignment of the fetch address. Further runs use all-no-op words, a slot-0 call, and an execution stage that holds back acceptance, which tests skipping and hold stability.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int WORD_W = 16;
  localparam int SLOT_W = 5;
  localparam int NUM_SLOTS = 4;
  localparam int IDX_W = $clog2(NUM_SLOTS);
  localparam int BYTE_W = 8;

  typedef logic [SLOT_W-1:0] opcode_t;

  localparam opcode_t OP_NOP  = 5'd0;
  localparam opcode_t OP_CALL = 5'd1;
  localparam opcode_t OP_JMP  = 5'd2;
  localparam opcode_t OP_LIT  = 5'd4;
  localparam opcode_t OP_LITB = 5'd5;

  typedef struct packed {
    logic loadWord;
    logic captureLit;
    logic advanceSlot;
    logic takeBranch;
    logic finishWord;
    logic litAddrSel;
  } ctrl_t;
endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  input  logic [WORD_W-1:0] imemData,
  input  logic [ADDR_W-1:0] stackTop,
  output opcode_t           curOp,
  output logic              lastSlot,
  output logic [ADDR_W-1:0] imemAddr,
  output logic [WORD_W-1:0] opLiteral,
  output logic [ADDR_W-1:0] opTarget,
  output logic [ADDR_W-1:0] opLink
);
  logic [ADDR_W-1:0] pcQ, litAddrQ;
  logic [WORD_W-1:0] wordQ, litQ;
  logic [IDX_W-1:0]  slotQ;
  logic              byteHalfQ;

  logic [4:0]        remBits;
  logic [ADDR_W-1:0] lowMask;
  logic [ADDR_W-1:0] nextSeq;
  logic [ADDR_W-1:0] litFetch;

  assign lastSlot = (slotQ == IDX_W'(NUM_SLOTS - 1));
  assign remBits  = 5'(WORD_W - 1 - SLOT_W * int'(slotQ));

  always_comb begin
    if (slotQ == '0) curOp = wordQ[WORD_W-1] ? OP_CALL : OP_NOP;
    else             curOp = wordQ[remBits +: SLOT_W];
  end

  assign lowMask = (ADDR_W'(1) << remBits) - ADDR_W'(1);
  assign nextSeq = litAddrQ + ADDR_W'(byteHalfQ);

  always_comb begin
    if (lastSlot) opTarget = stackTop;
    else          opTarget = (pcQ & ~lowMask) | (ADDR_W'(wordQ) & lowMask);
  end

  assign litFetch  = (curOp == OP_LIT) ? nextSeq : litAddrQ;
  assign imemAddr  = ctl.litAddrSel ? litFetch : pcQ;
  assign opLiteral = litQ;
  assign opLink    = nextSeq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ       <= RESET_PC;
      litAddrQ  <= '0;
      wordQ     <= '0;
      litQ      <= '0;
      slotQ     <= '0;
      byteHalfQ <= 1'b0;
    end else begin
      if (ctl.loadWord) begin
        wordQ     <= imemData;
        slotQ     <= '0;
        litAddrQ  <= pcQ + ADDR_W'(1);
        byteHalfQ <= 1'b0;
        litQ      <= '0;
      end
      if (ctl.captureLit) begin
        if (curOp == OP_LIT) begin
          litQ      <= imemData;
          litAddrQ  <= nextSeq + ADDR_W'(1);
          byteHalfQ <= 1'b0;
        end else begin
          litQ      <= WORD_W'(byteHalfQ ? imemData[BYTE_W-1:0]
                                         : imemData[WORD_W-1 -: BYTE_W]);
          litAddrQ  <= nextSeq;
          byteHalfQ <= ~byteHalfQ;
        end
      end
      if (ctl.advanceSlot) slotQ <= slotQ + IDX_W'(1);
      if (ctl.takeBranch)  pcQ <= opTarget;
      if (ctl.finishWord)  pcQ <= nextSeq;
    end
  end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  opcode_t curOp,
  input  logic    lastSlot,
  input  logic    opDone,
  output ctrl_t   ctl,
  output logic    opValid
);
  typedef enum logic [2:0] {
    ST_FETCH, ST_LOAD, ST_ISSUE, ST_LITRD, ST_EXEC
  } state_t;

  state_t stateQ, stateNxt;
  logic   isLit, isBranch;

  assign isLit    = (curOp == OP_LIT) || (curOp == OP_LITB);
  assign isBranch = (curOp == OP_CALL) || (curOp == OP_JMP);

  always_comb begin
    ctl      = '0;
    opValid  = 1'b0;
    stateNxt = stateQ;
    unique case (stateQ)
      ST_FETCH: stateNxt = ST_LOAD;
      ST_LOAD: begin
        ctl.loadWord = 1'b1;
        stateNxt     = ST_ISSUE;
      end
      ST_ISSUE: begin
        if (curOp == OP_NOP) begin
          if (lastSlot) begin
            ctl.finishWord = 1'b1;
            stateNxt       = ST_FETCH;
          end else begin
            ctl.advanceSlot = 1'b1;
          end
        end else if (isLit) begin
          ctl.litAddrSel = 1'b1;
          stateNxt       = ST_LITRD;
        end else begin
          stateNxt = ST_EXEC;
        end
      end
      ST_LITRD: begin
        ctl.captureLit = 1'b1;
        ctl.litAddrSel = 1'b1;
        stateNxt       = ST_EXEC;
      end
      ST_EXEC: begin
        opValid = 1'b1;
        if (opDone) begin
          if (isBranch) begin
            ctl.takeBranch = 1'b1;
            stateNxt       = ST_FETCH;
          end else if (lastSlot) begin
            ctl.finishWord = 1'b1;
            stateNxt       = ST_FETCH;
          end else begin
            ctl.advanceSlot = 1'b1;
            stateNxt        = ST_ISSUE;
          end
        end
      end
      default: stateNxt = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_FETCH;
    else       stateQ <= stateNxt;
  end
endmodule

// File: rtl/packed_slot_seq.sv
module packed_slot_seq
  import seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] imemAddr,
  input  logic [WORD_W-1:0] imemData,
  input  logic [ADDR_W-1:0] stackTop,
  output logic              opValid,
  output logic [SLOT_W-1:0] opCode,
  output logic [WORD_W-1:0] opLiteral,
  output logic [ADDR_W-1:0] opTarget,
  output logic [ADDR_W-1:0] opLink,
  input  logic              opDone
);
  ctrl_t   ctl;
  opcode_t curOp;
  logic    lastSlot;

  seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .curOp    (curOp),
    .lastSlot (lastSlot),
    .opDone   (opDone),
    .ctl      (ctl),
    .opValid  (opValid)
  );

  seq_datapath #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .imemData  (imemData),
    .stackTop  (stackTop),
    .curOp     (curOp),
    .lastSlot  (lastSlot),
    .imemAddr  (imemAddr),
    .opLiteral (opLiteral),
    .opTarget  (opTarget),
    .opLink    (opLink)
  );

  assign opCode = curOp;
endmodule

// File: rtl/seq_checker.sv
module seq_checker
  import seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] imemAddr,
  input logic              opValid,
  input logic [SLOT_W-1:0] opCode,
  input logic [WORD_W-1:0] opLiteral,
  input logic [ADDR_W-1:0] opTarget,
  input logic              opDone
);
  // R3: held output stays put until accepted
  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    opValid && !opDone |=> opValid && $stable(opCode) && $stable(opLiteral) && $stable(opTarget));

  // R3: accepted opcode drops valid the following cycle
  assert_valid_drop_R3: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opDone |=> !opValid);

  // R2: no-op never presented
  assert_no_nop_R2: assert property (@(posedge clk) disable iff (!rstN)
    opValid |-> opCode != OP_NOP);

  // R9: byte literal is zero-extended
  assert_byte_zext_R9: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opCode == OP_LITB |-> opLiteral[WORD_W-1:BYTE_W] == '0);

  // R7: accepted branch fetches its destination next
  assert_branch_fetch_R7: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opDone && (opCode == OP_CALL || opCode == OP_JMP)
    |=> imemAddr == $past(opTarget));
endmodule

bind packed_slot_seq seq_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_packed_slot_seq.sv
`timescale 1ns/1ps
module tb_packed_slot_seq;
  localparam logic [4:0] K_NOP = 5'd0, K_CALL = 5'd1, K_JMP = 5'd2,
                         K_LIT = 5'd4, K_LITB = 5'd5;
  localparam int MAXEV = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] imemAddr, imemData, stackTop, opLiteral, opTarget, opLink;
  logic        opValid, opDone = 1'b0;
  logic [4:0]  opCode;

  logic [15:0] mem [0:1023];
  int checks = 0, failures = 0, cycles = 0;
  int stallCycles = 0, holdCnt = 0, evCount = 0;
  logic [4:0]  gotOp [MAXEV];
  logic [15:0] gotLit [MAXEV], gotTgt [MAXEV], gotLink [MAXEV];
  logic [4:0]  expOp [MAXEV];
  logic [15:0] expLit [MAXEV], expTgt [MAXEV], expLink [MAXEV];
  int          expSlot [MAXEV];
  logic [4:0]  snapOp;
  logic [15:0] snapLit, snapTgt;

  packed_slot_seq dut (
    .clk(clk), .rstN(rstN), .imemAddr(imemAddr), .imemData(imemData),
    .stackTop(stackTop), .opValid(opValid), .opCode(opCode),
    .opLiteral(opLiteral), .opTarget(opTarget), .opLink(opLink), .opDone(opDone)
  );

  always #2 clk = ~clk;

  always @(posedge clk) imemData <= mem[imemAddr[9:0]];

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired: actual=%0d cycles expected<150000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // executor: accepts opcodes, optionally after a stall, and checks hold stability (R3)
  always @(negedge clk) begin
    if (rstN && opValid) begin
      if (holdCnt == 0) begin
        snapOp = opCode; snapLit = opLiteral; snapTgt = opTarget;
      end else begin
        check(opCode == snapOp, "R3 opcode hold", {11'b0, opCode}, {11'b0, snapOp});
        check(opLiteral == snapLit && opTarget == snapTgt, "R3 operand hold", opLiteral, snapLit);
      end
      if (holdCnt < stallCycles) begin
        holdCnt++;
        opDone = 1'b0;
      end else begin
        if (evCount < MAXEV) begin
          gotOp[evCount] = opCode; gotLit[evCount] = opLiteral;
          gotTgt[evCount] = opTarget; gotLink[evCount] = opLink;
        end
        evCount++;
        holdCnt = 0;
        opDone = 1'b1;
      end
    end else begin
      opDone = 1'b0;
      holdCnt = 0;
    end
  end

  function automatic logic [15:0] mk(input logic s0, input logic [4:0] s1,
                                     input logic [4:0] s2, input logic [4:0] s3);
    return {s0, s1, s2, s3};
  endfunction

  task automatic clearMem();
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
  endtask

  // reference model of the slot rules
  task automatic runModel(input int n);
    logic [15:0] pc, la, w, tgt, mask, lit, nextPc;
    logic bh, taken;
    logic [4:0] op;
    int cnt, guard;
    pc = 16'h0000; cnt = 0; guard = 0;
    while (cnt < n && guard < 300) begin
      w = mem[pc[9:0]]; la = pc + 16'd1; bh = 1'b0; taken = 1'b0; nextPc = 16'h0;
      for (int s = 0; s < 4; s++) begin
        if (!taken && cnt < n) begin
          op = (s == 0) ? (w[15] ? K_CALL : K_NOP) : w[(19 - 5 * s) -: 5];
          if (op != K_NOP) begin
            lit = 16'h0; tgt = 16'h0;
            if (op == K_LIT) begin
              la = la + {15'b0, bh}; lit = mem[la[9:0]]; la = la + 16'd1; bh = 1'b0;
            end else if (op == K_LITB) begin
              lit = bh ? {8'h00, mem[la[9:0]][7:0]} : {8'h00, mem[la[9:0]][15:8]};
              if (bh) la = la + 16'd1;
              bh = ~bh;
            end
            if (op == K_CALL || op == K_JMP) begin
              if (s == 3) tgt = stackTop;
              else begin
                mask = (16'd1 << (15 - 5 * s)) - 16'd1;
                tgt = (pc & ~mask) | (w & mask);
              end
              taken = 1'b1; nextPc = tgt;
            end
            expOp[cnt] = op; expLit[cnt] = lit; expTgt[cnt] = tgt;
            expLink[cnt] = la + {15'b0, bh}; expSlot[cnt] = s;
            cnt++;
          end
        end
      end
      pc = taken ? nextPc : la + {15'b0, bh};
      guard++;
    end
  endtask

  task automatic resetDut();
    rstN = 1'b0;
    evCount = 0;
    repeat (3) @(negedge clk);
    check(opValid == 1'b0, "R11 valid low in reset", {15'b0, opValid}, 16'h0);
    check(imemAddr == 16'h0000, "R11 reset fetch address", imemAddr, 16'h0000);
    rstN = 1'b1;
  endtask

  task automatic runAndCompare(input string name, input int n);
    int waitCnt;
    runModel(n);
    resetDut();
    waitCnt = 0;
    while (evCount < n && waitCnt < 3000) begin
      @(negedge clk);
      waitCnt++;
    end
    check(evCount >= n, "R1 R2 event count", 16'(evCount), 16'(n));
    for (int i = 0; i < n && i < evCount; i++) begin
      // opcode order covers slot order, no-op skipping, discard after branch, realigned fetch
      check(gotOp[i] == expOp[i], "R1 R2 R7 R10 opcode sequence", {11'b0, gotOp[i]}, {11'b0, expOp[i]});
      if (expOp[i] == K_LIT)
        check(gotLit[i] == expLit[i], "R8 word literal", gotLit[i], expLit[i]);
      if (expOp[i] == K_LITB)
        check(gotLit[i] == expLit[i], "R9 byte literal", gotLit[i], expLit[i]);
      if ((expOp[i] == K_CALL || expOp[i] == K_JMP) && expSlot[i] == 3)
        check(gotTgt[i] == expTgt[i], "R5 stack destination", gotTgt[i], expTgt[i]);
      if ((expOp[i] == K_CALL || expOp[i] == K_JMP) && expSlot[i] != 3)
        check(gotTgt[i] == expTgt[i], "R4 slot destination", gotTgt[i], expTgt[i]);
      if (expOp[i] == K_CALL)
        check(gotLink[i] == expLink[i], "R6 call link", gotLink[i], expLink[i]);
    end
    $display("scenario %s done", name);
  endtask

  task automatic loadBranchProgram();
    clearMem();
    mem[16'h000] = mk(0, 5'h10, 5'h11, 5'h12);
    mem[16'h001] = {1'b0, K_JMP, 10'h040};
    mem[16'h040] = {1'b1, 15'h0080};
    mem[16'h080] = mk(0, 5'h13, K_JMP, 5'h1F);
    mem[16'h09F] = mk(0, 5'h10, 5'h11, K_JMP);
    mem[16'h123] = mk(0, 5'h14, K_CALL, 5'h05);
  endtask

  // R4 R5 R6 R7: branches in every slot
  task automatic testBranches();
    loadBranchProgram();
    stackTop = 16'h0123; stallCycles = 0;
    runAndCompare("branches", 12);
  endtask

  // R8 R9 R10: mixed literals
  task automatic testLiterals();
    clearMem();
    mem[0]  = mk(0, K_LIT, K_LITB, K_LITB);
    mem[1]  = 16'hBEEF; mem[2] = 16'hA55A;
    mem[3]  = mk(0, K_LITB, 5'h10, K_LIT);
    mem[4]  = 16'h1234; mem[5] = 16'hCAFE;
    mem[6]  = mk(0, K_LITB, K_NOP, K_NOP);
    mem[7]  = 16'h7788;
    mem[8]  = mk(0, K_LIT, K_CALL, 5'h14);
    mem[9]  = 16'h0F0F;
    mem[20] = mk(0, 5'h11, K_LITB, K_CALL);
    mem[21] = 16'h99AA;
    stackTop = 16'h0200; stallCycles = 0;
    runAndCompare("literals", 12);
  endtask

  // R2 R4: all-no-op word skipped, slot-0 call with 15-bit reach
  task automatic testNopAndSlot0();
    clearMem();
    mem[1] = mk(0, K_NOP, K_NOP, 5'h10);
    mem[2] = {1'b1, 15'h0300};
    mem[16'h300] = mk(0, 5'h1A, K_NOP, K_NOP);
    stackTop = 16'h0000; stallCycles = 0;
    runAndCompare("nop_slot0", 3);
  endtask

  // R3: execution stage holds back acceptance
  task automatic testStall();
    loadBranchProgram();
    stackTop = 16'h0123; stallCycles = 2;
    runAndCompare("stall", 12);
    stallCycles = 0;
  endtask

  initial begin
    stackTop = 16'h0;
    clearMem();
    testBranches();
    testLiterals();
    testNopAndSlot0();
    testStall();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule